// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox with Busy Lock

This block sits between a system bus that delivers interrupt messages and a set of CPUs. Each incoming message names a target CPU and carries a 5-bit source identifier and two data words. The block holds one mailbox per CPU. A mailbox stores a busy flag, the source identifier and both data words. A message is taken only when the target's mailbox is free. If the mailbox is busy, the sender is told to retry, and the answer comes in the same cycle as the request. When a message is taken, the block locks the mailbox and raises a post strobe toward the target CPU. The strobe carries one interrupt vector that all CPUs share and that software can program.

Software reads the mailboxes through a small register window. Each mailbox can be reached at a fixed stride. A set of alias addresses also reaches it, and these pick the mailbox of the CPU that makes the access. Software frees a mailbox by writing the busy bit of its status register.

Top module: `cpu_mailbox`

## Requirements
- R1: After reset every mailbox is free with zero source and data, the shared vector is 0, and postValid and regRdValid are low.
- R2: While msgValid is high, exactly one of msgAccept or msgRetry is high in that same cycle. msgAccept is high exactly when the target mailbox is free. A target at or above NUM_CPU counts as busy. Both outputs are low while msgValid is low.
- R3: An accepted message sets the target's busy flag and stores its source identifier and both data words. A read issued in any later cycle shows all of these.
- R4: A refused message changes no mailbox state.
- R5: One cycle after an accept, postValid pulses with postCpu equal to the target. postVector equals the shared vector value held in the cycle of the accept.
- R6: A status read returns the busy flag at bit 5 and the source identifier at bits 4:0. All higher bits read 0.
- R7: Indexed registers sit at a stride of 8 bytes. Data word 0 of CPU i is at 0x000+8i, data word 1 at 0x100+8i, and status at 0x200+8i.
- R8: The alias addresses pick the mailbox of reqCpu. They are 0x300 for data word 0, 0x308 for data word 1 and 0x310 for status.
- R9: A write to a status register (indexed or alias) loads busy from bit 5 of the write data. The source identifier and data words are kept.
- R10: If a message to a CPU is accepted in the same cycle that software writes that CPU's busy bit, the accept wins and busy stays set.
- R11: The shared vector register at 0x318 holds bits 5:0 of the write data and reads back zero-extended.
- R12: Read data appears with regRdValid one cycle after regRdEn and reflects the state before that edge. The following read as 0: an address with nonzero bits 2:0, an index at or above NUM_CPU, or an unused alias slot. Writes to data-word registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | Incoming interrupt message present |
| msgCpu | input | CPU_W | Target CPU of the message |
| msgSrc | input | 5 | Source identifier of the message |
| msgData0 | input | DATA_W | First data word |
| msgData1 | input | DATA_W | Second data word |
| msgAccept | output | 1 | Message taken (same cycle) |
| msgRetry | output | 1 | Message refused, sender must retry (same cycle) |
| postValid | output | 1 | Interrupt post strobe |
| postCpu | output | CPU_W | CPU that receives the post |
| postVector | output | 6 | Shared vector sent with the post |
| regRdEn | input | 1 | Register read request |
| regWrEn | input | 1 | Register write request |
| regAddr | input | 10 | Register byte offset |
| regWrData | input | 6 | Write data; only bits 5:0 hold writable fields |
| reqCpu | input | CPU_W | CPU making the register access (alias selector) |
| regRdValid | output | 1 | Read data valid |
| regRdData | output | DATA_W | Read data |

## Verification
The embedded assertions check, on every cycle, the handshake properties. Each valid message gets exactly one outcome, and nothing is signalled while idle. They also check that an accept is followed by a locked mailbox and a post pulse to the right CPU with the vector held at that moment. Read valid must track read requests, and status reads must never carry bits above the busy flag. Only the bench scenarios can show the rest: what the stored words contain, the address decode with its stride, alias selection by reqCpu, unmapped addresses returning zero, a refused message leaving contents alone, and the accept-beats-clear collision. These depend on values written earlier and then read back through the register window.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  // Register window layout: [9:8] region, [7:3] slot, [2:0] byte within word
  localparam int REGION_W = 2;
  localparam int SLOT_W   = 5;
  localparam int ALIGN_W  = 3;
  localparam int ADDR_W   = REGION_W + SLOT_W + ALIGN_W;
  localparam int SRC_W    = 5;
  localparam int VEC_W    = 6;
  localparam int WR_W     = 6;
  localparam int BUSY_BIT = 5;

  localparam logic [REGION_W-1:0] REGION_WORD0  = 2'd0;
  localparam logic [REGION_W-1:0] REGION_WORD1  = 2'd1;
  localparam logic [REGION_W-1:0] REGION_STATUS = 2'd2;
  localparam logic [REGION_W-1:0] REGION_ALIAS  = 2'd3;

  localparam logic [SLOT_W-1:0] ALIAS_WORD0  = 5'd0;
  localparam logic [SLOT_W-1:0] ALIAS_WORD1  = 5'd1;
  localparam logic [SLOT_W-1:0] ALIAS_STATUS = 5'd2;
  localparam logic [SLOT_W-1:0] ALIAS_VECTOR = 5'd3;

  typedef enum logic [2:0] {
    RD_NONE, RD_WORD0, RD_WORD1, RD_STATUS, RD_VECTOR
  } rdKind_e;

  typedef struct packed {
    logic              acceptEn;
    logic [SLOT_W-1:0] acceptSlot;
    logic              busyWrEn;
    logic [SLOT_W-1:0] busyWrSlot;
    logic              busyWrVal;
    logic              vecWrEn;
    logic [VEC_W-1:0]  vecWrVal;
    logic              rdEn;
    rdKind_e           rdKind;
    logic [SLOT_W-1:0] rdSlot;
  } strobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
`timescale 1ns/1ps
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msgValid,
  input  logic [CPU_W-1:0]     msgCpu,
  input  logic [NUM_CPU-1:0]   busyVec,
  input  logic                 regRdEn,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [WR_W-1:0]      regWrData,
  input  logic [CPU_W-1:0]     reqCpu,
  output logic                 msgAccept,
  output logic                 msgRetry,
  output strobes_t             st
);
  localparam int CMP_W = SLOT_W + 1;

  logic [REGION_W-1:0] region;
  logic [SLOT_W-1:0]   slot;
  logic [SLOT_W-1:0]   tgtSlot;
  logic [SLOT_W-1:0]   reqSlot;
  logic                aligned;
  logic                slotOk;
  logic                reqOk;
  logic                tgtOk;
  logic                tgtBusy;

  function automatic logic inRange(input logic [SLOT_W-1:0] s);
    return {1'b0, s} < CMP_W'(NUM_CPU);
  endfunction

  assign region  = regAddr[ADDR_W-1 -: REGION_W];
  assign slot    = regAddr[ALIGN_W +: SLOT_W];
  assign aligned = (regAddr[ALIGN_W-1:0] == '0);
  assign tgtSlot = SLOT_W'(msgCpu);
  assign reqSlot = SLOT_W'(reqCpu);
  assign slotOk  = inRange(slot);
  assign reqOk   = inRange(reqSlot);
  assign tgtOk   = inRange(tgtSlot);

  // Out-of-range targets are treated as permanently busy
  assign tgtBusy   = tgtOk ? busyVec[msgCpu] : 1'b1;
  assign msgAccept = msgValid && !tgtBusy;
  assign msgRetry  = msgValid && tgtBusy;

  always_comb begin
    st            = '0;
    st.acceptEn   = msgAccept;
    st.acceptSlot = tgtSlot;
    st.rdEn       = regRdEn;
    st.rdKind     = RD_NONE;
    st.busyWrVal  = regWrData[BUSY_BIT];
    st.vecWrVal   = regWrData[VEC_W-1:0];
    if (aligned) begin
      unique case (region)
        REGION_WORD0: if (slotOk) begin
          st.rdKind = RD_WORD0;
          st.rdSlot = slot;
        end
        REGION_WORD1: if (slotOk) begin
          st.rdKind = RD_WORD1;
          st.rdSlot = slot;
        end
        REGION_STATUS: if (slotOk) begin
          st.rdKind     = RD_STATUS;
          st.rdSlot     = slot;
          st.busyWrEn   = regWrEn;
          st.busyWrSlot = slot;
        end
        REGION_ALIAS: begin
          unique case (slot)
            ALIAS_WORD0: if (reqOk) begin
              st.rdKind = RD_WORD0;
              st.rdSlot = reqSlot;
            end
            ALIAS_WORD1: if (reqOk) begin
              st.rdKind = RD_WORD1;
              st.rdSlot = reqSlot;
            end
            ALIAS_STATUS: if (reqOk) begin
              st.rdKind     = RD_STATUS;
              st.rdSlot     = reqSlot;
              st.busyWrEn   = regWrEn;
              st.busyWrSlot = reqSlot;
            end
            ALIAS_VECTOR: begin
              st.rdKind  = RD_VECTOR;
              st.vecWrEn = regWrEn;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // R2: a valid message always gets one and only one outcome
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAccept != msgRetry));
  // R2: nothing is signalled without a message
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |-> (!msgAccept && !msgRetry));
endmodule

// File: rtl/mbox_datapath.sv
`timescale 1ns/1ps
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           st,
  input  logic [SRC_W-1:0]   msgSrc,
  input  logic [DATA_W-1:0]  msgData0,
  input  logic [DATA_W-1:0]  msgData1,
  output logic [NUM_CPU-1:0] busyVec,
  output logic               postValid,
  output logic [CPU_W-1:0]   postCpu,
  output logic [VEC_W-1:0]   postVector,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] word0 [NUM_CPU];
  logic [DATA_W-1:0] word1 [NUM_CPU];
  logic [SRC_W-1:0]  srcId [NUM_CPU];
  logic [VEC_W-1:0]  vecReg;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyVec <= '0;
      for (int i = 0; i < NUM_CPU; i++) begin
        word0[i] <= '0;
        word1[i] <= '0;
        srcId[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CPU; i++) begin
        // Accept has priority over a software busy write to the same mailbox
        if (st.acceptEn && st.acceptSlot == SLOT_W'(i)) begin
          busyVec[i] <= 1'b1;
          srcId[i]   <= msgSrc;
          word0[i]   <= msgData0;
          word1[i]   <= msgData1;
        end else if (st.busyWrEn && st.busyWrSlot == SLOT_W'(i)) begin
          busyVec[i] <= st.busyWrVal;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           vecReg <= '0;
    else if (st.vecWrEn) vecReg <= st.vecWrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postValid  <= 1'b0;
      postCpu    <= '0;
      postVector <= '0;
    end else begin
      postValid <= st.acceptEn;
      if (st.acceptEn) begin
        postCpu    <= st.acceptSlot[CPU_W-1:0];
        postVector <= vecReg;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (st.rdKind == RD_VECTOR) rdNext = DATA_W'(vecReg);
    for (int i = 0; i < NUM_CPU; i++) begin
      if (st.rdSlot == SLOT_W'(i)) begin
        unique case (st.rdKind)
          RD_WORD0:  rdNext = word0[i];
          RD_WORD1:  rdNext = word1[i];
          RD_STATUS: rdNext = DATA_W'({busyVec[i], srcId[i]});
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.rdEn;
      if (st.rdEn) rdData <= rdNext;
    end
  end

  // R3 / R10: an accepted message always leaves the mailbox locked
  a_r3_locked_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    st.acceptEn |=> busyVec[$past(st.acceptSlot[CPU_W-1:0])]);
  // R5: post pulse follows an accept and carries the vector held at accept time
  a_r5_post_pulse: assert property (@(posedge clk) disable iff (!rstN)
    st.acceptEn |=> (postValid && postVector == $past(vecReg)));
  a_r5_no_spurious_post: assert property (@(posedge clk) disable iff (!rstN)
    !st.acceptEn |=> !postValid);
  // R12: read data valid one cycle after each request
  a_r12_rd_follows: assert property (@(posedge clk) disable iff (!rstN)
    st.rdEn |=> rdValid);
  a_r12_rd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !st.rdEn |=> !rdValid);
  // R6: status reads carry nothing above the busy bit
  a_r6_status_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && st.rdKind == RD_STATUS) |=> (rdData[DATA_W-1:BUSY_BIT+1] == '0));
endmodule

// File: rtl/cpu_mailbox.sv
`timescale 1ns/1ps
module cpu_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int DATA_W  = 64,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [CPU_W-1:0]  msgCpu,
  input  logic [4:0]        msgSrc,
  input  logic [DATA_W-1:0] msgData0,
  input  logic [DATA_W-1:0] msgData1,
  output logic              msgAccept,
  output logic              msgRetry,
  output logic              postValid,
  output logic [CPU_W-1:0]  postCpu,
  output logic [5:0]        postVector,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [9:0]        regAddr,
  input  logic [5:0]        regWrData,
  input  logic [CPU_W-1:0]  reqCpu,
  output logic              regRdValid,
  output logic [DATA_W-1:0] regRdData
);
  strobes_t           st;
  logic [NUM_CPU-1:0] busyVec;

  mbox_ctrl #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .msgValid(msgValid), .msgCpu(msgCpu), .busyVec(busyVec),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .reqCpu(reqCpu),
    .msgAccept(msgAccept), .msgRetry(msgRetry), .st(st)
  );

  mbox_datapath #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .msgSrc(msgSrc), .msgData0(msgData0), .msgData1(msgData1),
    .busyVec(busyVec),
    .postValid(postValid), .postCpu(postCpu), .postVector(postVector),
    .rdValid(regRdValid), .rdData(regRdData)
  );

  // R5: the post goes to the CPU the message was accepted for
  a_r5_post_target: assert property (@(posedge clk) disable iff (!rstN)
    msgAccept |=> (postCpu == $past(msgCpu)));
endmodule

// File: tb/tb_cpu_mailbox.sv
`timescale 1ns/1ps
module tb_cpu_mailbox;
  localparam int NCPU = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 0;
  logic [2:0]  msgCpu = 0;
  logic [4:0]  msgSrc = 0;
  logic [63:0] msgData0 = 0, msgData1 = 0;
  logic        msgAccept, msgRetry, postValid;
  logic [2:0]  postCpu;
  logic [5:0]  postVector;
  logic        regRdEn = 0, regWrEn = 0;
  logic [9:0]  regAddr = 0;
  logic [5:0]  regWrData = 0;
  logic [2:0]  reqCpu = 0;
  logic        regRdValid;
  logic [63:0] regRdData;

  always #5 clk = ~clk;

  cpu_mailbox #(.NUM_CPU(NCPU), .DATA_W(64)) dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgCpu(msgCpu), .msgSrc(msgSrc),
    .msgData0(msgData0), .msgData1(msgData1), .msgAccept(msgAccept), .msgRetry(msgRetry),
    .postValid(postValid), .postCpu(postCpu), .postVector(postVector),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .reqCpu(reqCpu), .regRdValid(regRdValid), .regRdData(regRdData)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model
  logic        mBusy [NCPU];
  logic [4:0]  mSrc  [NCPU];
  logic [63:0] mW0   [NCPU];
  logic [63:0] mW1   [NCPU];
  logic [5:0]  mVec;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expRead(input logic [9:0] a, input int rc);
    int s = int'(a[7:3]);
    if (a[2:0] != 3'd0) return 64'd0;
    case (a[9:8])
      2'd0: return (s < NCPU) ? mW0[s] : 64'd0;
      2'd1: return (s < NCPU) ? mW1[s] : 64'd0;
      2'd2: return (s < NCPU) ? {58'd0, mBusy[s], mSrc[s]} : 64'd0;
      default: case (s)
        0: return mW0[rc];
        1: return mW1[rc];
        2: return {58'd0, mBusy[rc], mSrc[rc]};
        3: return {58'd0, mVec};
        default: return 64'd0;
      endcase
    endcase
  endfunction

  function automatic string readTag(input logic [9:0] a);
    if (a[2:0] != 3'd0) return "R12";
    if (a[9:8] == 2'd3) return (a[7:3] == 5'd3) ? "R11" : "R8";
    if (a[9:8] == 2'd2) return "R6";
    return "R7";
  endfunction

  // Drive one cycle from the v* variables and check against the model
  logic       vMv, vRd, vWr;
  logic [2:0] vCpu, vReq;
  logic [4:0] vSrc;
  logic [63:0] vD0, vD1;
  logic [9:0] vAddr;
  logic [5:0] vWd;

  task automatic step(input string tagOverride);
    logic expAcc;
    logic [63:0] expRd;
    logic [5:0] expVec;
    string rtag;
    int c, s;
    @(negedge clk);
    msgValid = vMv; msgCpu = vCpu; msgSrc = vSrc; msgData0 = vD0; msgData1 = vD1;
    regRdEn = vRd; regWrEn = vWr; regAddr = vAddr; regWrData = vWd; reqCpu = vReq;
    #1;
    c = int'(vCpu);
    expAcc = vMv && !mBusy[c];
    chk("R2 accept", {63'd0, msgAccept}, {63'd0, expAcc});
    chk("R2 retry", {63'd0, msgRetry}, {63'd0, vMv && !expAcc});
    expRd = expRead(vAddr, int'(vReq));
    expVec = mVec;
    rtag = (tagOverride != "") ? tagOverride : readTag(vAddr);
    @(posedge clk);
    #1;
    chk("R5 postValid", {63'd0, postValid}, {63'd0, expAcc});
    if (expAcc) begin
      chk("R5 postCpu", {61'd0, postCpu}, {61'd0, vCpu});
      chk("R5 postVector", {58'd0, postVector}, {58'd0, expVec});
    end
    chk("R12 rdValid", {63'd0, regRdValid}, {63'd0, vRd});
    if (vRd) chk({rtag, " rdData"}, regRdData, expRd);
    // Model update
    if (expAcc) begin
      mBusy[c] = 1'b1; mSrc[c] = vSrc; mW0[c] = vD0; mW1[c] = vD1;
    end
    if (vWr && vAddr[2:0] == 3'd0) begin
      s = int'(vAddr[7:3]);
      if (vAddr[9:8] == 2'd2 && s < NCPU && !(expAcc && c == s)) mBusy[s] = vWd[5];
      if (vAddr[9:8] == 2'd3 && s == 2 && !(expAcc && c == int'(vReq))) mBusy[vReq] = vWd[5];
      if (vAddr[9:8] == 2'd3 && s == 3) mVec = vWd;
    end
  endtask

  task automatic idle();
    vMv = 0; vRd = 0; vWr = 0; vCpu = 0; vSrc = 0; vD0 = 0; vD1 = 0;
    vAddr = 0; vWd = 0; vReq = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [2:0] rc, input string tag);
    idle(); vRd = 1; vAddr = a; vReq = rc; step(tag);
  endtask

  task automatic wr(input logic [9:0] a, input logic [5:0] d, input logic [2:0] rc);
    idle(); vWr = 1; vAddr = a; vWd = d; vReq = rc; step("");
  endtask

  task automatic send(input logic [2:0] c, input logic [4:0] s, input logic [63:0] d0,
                      input logic [63:0] d1);
    idle(); vMv = 1; vCpu = c; vSrc = s; vD0 = d0; vD1 = d1; step("");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int i = 0; i < NCPU; i++) begin
      mBusy[i] = 0; mSrc[i] = 0; mW0[i] = 0; mW1[i] = 0;
    end
    mVec = 0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the ports
    chk("R1 postValid", {63'd0, postValid}, 64'd0);
    chk("R1 rdValid", {63'd0, regRdValid}, 64'd0);
    @(negedge clk); rstN = 1;
    rd(10'h318, 0, "R1");
    for (int i = 0; i < NCPU; i++) rd(10'h200 + 10'(8 * i), 0, "R1");
    rd(10'h038, 0, "R1");

    // R3: accept and store
    send(3'd2, 5'h13, 64'hA5A5_0000_1234_5678, 64'h0F0F_FFFF_8765_4321);
    rd(10'h010, 0, "R3");
    rd(10'h110, 0, "R3");
    rd(10'h210, 0, "R3");
    // R4: refused message leaves contents alone
    send(3'd2, 5'h07, 64'h1111, 64'h2222);
    rd(10'h010, 0, "R4");
    rd(10'h110, 0, "R4");
    rd(10'h210, 0, "R4");
    // R8: aliases follow reqCpu
    rd(10'h300, 3'd2, "R8");
    rd(10'h308, 3'd2, "R8");
    rd(10'h310, 3'd2, "R8");
    rd(10'h310, 3'd3, "R8");
    // R9: clear busy, source kept, other bits of write data ignored
    wr(10'h210, 6'h1F, 0);
    rd(10'h210, 0, "R9");
    wr(10'h310, 6'h20, 3'd2);
    rd(10'h210, 0, "R9");
    wr(10'h310, 6'h00, 3'd2);
    // R11 / R5: vector programming and posting
    wr(10'h318, 6'h2A, 0);
    rd(10'h318, 0, "R11");
    send(3'd5, 5'h01, 64'hDEAD, 64'hBEEF);
    // R10: clear and accept for the same CPU in one cycle
    wr(10'h310, 6'h00, 3'd5);
    idle(); vMv = 1; vCpu = 3'd5; vSrc = 5'h0C; vD0 = 64'h77; vD1 = 64'h88;
    vWr = 1; vAddr = 10'h228; vWd = 6'h00; step("");
    rd(10'h228, 0, "R10");
    // R12: unmapped, misaligned, out-of-range, ignored data write
    rd(10'h011, 0, "R12");
    rd(10'h040, 0, "R12");
    rd(10'h320, 0, "R12");
    wr(10'h010, 6'h3F, 0);
    rd(10'h010, 0, "R12");
    // R12: read sees state before a simultaneous write
    idle(); vRd = 1; vWr = 1; vAddr = 10'h318; vWd = 6'h05; step("R12");
    rd(10'h318, 0, "R11");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      vMv  = ($urandom % 3) != 0;
      vCpu = 3'($urandom % NCPU);
      vSrc = 5'($urandom);
      vD0  = {$urandom, $urandom};
      vD1  = {$urandom, $urandom};
      vReq = 3'($urandom % NCPU);
      vRd  = ($urandom % 2) == 1;
      vWr  = ($urandom % 3) == 0;
      vWd  = 6'($urandom);
      if (vWr && ($urandom % 4) != 0)
        vAddr = (($urandom % 2) == 0) ? 10'h200 + 10'(8 * ($urandom % NCPU)) : 10'h310;
      else begin
        vAddr = {2'($urandom), 5'($urandom % 10), 3'd0};
        if (($urandom % 10) == 0) vAddr[2:0] = 3'($urandom);
      end
      step("");
    end

    idle(); step("");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule